// File: doc/BRIEF.md
# Per-CPU Highest-Priority Interrupt Selector

This block keeps, for every interrupt line, an enable bit, a pending bit, an 8-bit priority and (for shared lines) a mask of the CPUs the line is aimed at. For each CPU interface it scans all lines, picks the most urgent candidate, and turns that choice into two outputs. The first is the "highest pending" ID. The second is the CPU's interrupt request line.

Both outputs are gated by three things: the distributor and CPU group enables, a per-CPU priority-mask threshold, and the priority of the interrupt the CPU is already running. Lines 0 to 31 are private. Each CPU has its own enable, pending and priority copy of them, and they ignore the target mask. Lines 32 and above are shared. A write to a shared line updates every CPU's copy, and the target mask decides which CPUs see that line.

State is written through a simple single-entry write port. The decoding of a register bus sits outside this block.

Top module: `irq_hp_select`

## Requirements
- R1: After reset every enable, pending, priority and target is zero. Every `hppi_o` field reads 1023, every `irq_req_o` bit is low, and `settled_o` is high.
- R2: Among candidates, the one with the numerically smallest priority is selected.
- R3: When candidates tie on priority, the lowest ID is selected.
- R4: A line is a candidate for a CPU only when both its enable bit and its pending bit are set for that CPU. The write kind encodes as 0 = enable and 1 = pending, and the value is taken from `wr_data[0]`. For IDs below 32 a write touches only the copy of CPU `wr_cpu`; for other IDs it touches all copies.
- R5: A shared line (ID >= 32) is a candidate for CPU c only when bit c of its target mask is set. Write kind 2 stores `wr_data[NUM_CPU-1:0]` as that mask. A target write to an ID below 32 has no effect.
- R6: A CPU's `hppi_o` field shows the selected ID only when its priority is strictly less than that CPU's `pmask` byte; otherwise it shows 1023. Write kind 3 stores the priority from `wr_data`.
- R7: `irq_req_o[c]` is high only when `hppi_o` for c shows a selected ID and its priority is also strictly less than the 9-bit `run_prio` field of c. A value of 0x100 means the CPU is idle.
- R8: When `dist_grp_en` is 0, or the 2-bit `cpu_grp_en` field of a CPU is 0, that CPU's request is low and its `hppi_o` reads 1023.
- R9: The outputs reflect a write one cycle after the write is accepted. `settled_o` is low for exactly the cycle after an accepted write, and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_kind | input | 2 | 0 enable, 1 pending, 2 target, 3 priority |
| wr_cpu | input | CPU_W | CPU bank for private IDs |
| wr_id | input | 10 | Interrupt ID written (IDs >= NUM_IRQ ignored) |
| wr_data | input | 8 | Write value |
| dist_grp_en | input | 2 | Distributor group enables |
| cpu_grp_en | input | 2*NUM_CPU | Per-CPU group enables |
| pmask | input | 8*NUM_CPU | Per-CPU priority mask |
| run_prio | input | 9*NUM_CPU | Per-CPU running priority |
| irq_req_o | output | NUM_CPU | Per-CPU interrupt request |
| hppi_o | output | 10*NUM_CPU | Per-CPU highest pending ID |
| settled_o | output | 1 | Outputs reflect all accepted writes |

## Verification
The priority-mask test and the running-priority test are judged in the same cycle on the same winner. The bench provokes this by moving each threshold to exactly the winner's priority and then one step above it. Each time, it checks that the published ID and the request line separate in the expected way. Selection and banking also meet in one scan: a private line and a shared line with equal priority compete on one CPU. The bench expects the lower ID to win there, while the other CPU, which lacks that private line, is expected to keep the shared winner.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
    localparam int ID_W      = 10;
    localparam int PRIO_W    = 8;
    localparam int PRIV_IDS  = 32;
    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

    typedef enum logic [1:0] {
        WK_ENABLE = 2'd0,
        WK_PEND   = 2'd1,
        WK_TARGET = 2'd2,
        WK_PRIO   = 2'd3
    } wkind_t;
endpackage

// File: rtl/irq_sel_store.sv
module irq_sel_store
    import irq_sel_pkg::*;
#(
    parameter int NUM_CPU = 2,
    parameter int NUM_IRQ = 64,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int IDX_W  = $clog2(NUM_IRQ)
) (
    input  logic                                           clk,
    input  logic                                           rst_n,
    input  logic                                           wr_en,
    input  logic [1:0]                                     wr_kind,
    input  logic [CPU_W-1:0]                               wr_cpu,
    input  logic [ID_W-1:0]                                wr_id,
    input  logic [PRIO_W-1:0]                              wr_data,
    output logic [NUM_CPU-1:0][NUM_IRQ-1:0]                en_o,
    output logic [NUM_CPU-1:0][NUM_IRQ-1:0]                pend_o,
    output logic [NUM_CPU-1:0][NUM_IRQ-1:0][PRIO_W-1:0]    prio_o,
    output logic [NUM_IRQ-1:0][NUM_CPU-1:0]                tgt_o
);
    typedef struct packed {
        logic [NUM_CPU-1:0][NUM_IRQ-1:0]             en;
        logic [NUM_CPU-1:0][NUM_IRQ-1:0]             pend;
        logic [NUM_CPU-1:0][NUM_IRQ-1:0][PRIO_W-1:0] prio;
        logic [NUM_IRQ-1:0][NUM_CPU-1:0]             tgt;
    } store_t;

    store_t st_d, st_q;
    logic   in_range;
    logic   shared_id;
    logic [IDX_W-1:0] idx;

    assign in_range  = wr_id < ID_W'(NUM_IRQ);
    assign shared_id = wr_id >= ID_W'(PRIV_IDS);
    assign idx       = wr_id[IDX_W-1:0];

    always_comb begin
        st_d = st_q;
        if (wr_en && in_range) begin
            for (int c = 0; c < NUM_CPU; c++) begin
                if (shared_id || (wr_cpu == CPU_W'(c))) begin
                    case (wkind_t'(wr_kind))
                        WK_ENABLE: st_d.en[c][idx]   = wr_data[0];
                        WK_PEND:   st_d.pend[c][idx] = wr_data[0];
                        WK_PRIO:   st_d.prio[c][idx] = wr_data;
                        default: ;
                    endcase
                end
            end
            if (shared_id && (wkind_t'(wr_kind) == WK_TARGET))
                st_d.tgt[idx] = wr_data[NUM_CPU-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o   = st_q.en;
    assign pend_o = st_q.pend;
    assign prio_o = st_q.prio;
    assign tgt_o  = st_q.tgt;

    // Shared lines keep identical enable copies in every CPU bank (R4)
    generate
        for (genvar c = 1; c < NUM_CPU; c++) begin : g_bank_chk
            p_shared_banks_r4: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.en[c][NUM_IRQ-1:PRIV_IDS] == st_q.en[0][NUM_IRQ-1:PRIV_IDS]);
        end
    endgenerate
endmodule

// File: rtl/irq_sel_scan.sv
module irq_sel_scan
    import irq_sel_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic [NUM_IRQ-1:0]             en,
    input  logic [NUM_IRQ-1:0]             pend,
    input  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio,
    input  logic [NUM_IRQ-1:0]             tgt_bit,
    input  logic                           grp_ok,
    input  logic [PRIO_W-1:0]              pmask,
    input  logic [PRIO_W:0]                run_prio,
    output logic [ID_W-1:0]                hppi,
    output logic                           req,
    output logic [PRIO_W:0]                best_prio
);
    logic [ID_W-1:0] best_id;

    always_comb begin
        best_prio = 9'h100;
        best_id   = SPURIOUS_ID;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (en[i] && pend[i] && ((i < PRIV_IDS) || tgt_bit[i])
                && ({1'b0, prio[i]} < best_prio)) begin
                best_prio = {1'b0, prio[i]};
                best_id   = ID_W'(i);
            end
        end
        hppi = SPURIOUS_ID;
        req  = 1'b0;
        if (grp_ok && (best_prio < {1'b0, pmask})) begin
            hppi = best_id;
            req  = best_prio < run_prio;
        end
    end
endmodule

// File: rtl/irq_hp_select.sv
module irq_hp_select
    import irq_sel_pkg::*;
#(
    parameter int NUM_CPU = 2,
    parameter int NUM_IRQ = 64,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [1:0]                wr_kind,
    input  logic [CPU_W-1:0]          wr_cpu,
    input  logic [ID_W-1:0]           wr_id,
    input  logic [PRIO_W-1:0]         wr_data,
    input  logic [1:0]                dist_grp_en,
    input  logic [2*NUM_CPU-1:0]      cpu_grp_en,
    input  logic [8*NUM_CPU-1:0]      pmask,
    input  logic [9*NUM_CPU-1:0]      run_prio,
    output logic [NUM_CPU-1:0]        irq_req_o,
    output logic [ID_W*NUM_CPU-1:0]   hppi_o,
    output logic                      settled_o
);
    logic [NUM_CPU-1:0][NUM_IRQ-1:0]             en, pend;
    logic [NUM_CPU-1:0][NUM_IRQ-1:0][PRIO_W-1:0] prio;
    logic [NUM_IRQ-1:0][NUM_CPU-1:0]             tgt;
    logic [NUM_CPU-1:0][NUM_IRQ-1:0]             tgt_col;

    logic [NUM_CPU-1:0][ID_W-1:0]   hppi_c;
    logic [NUM_CPU-1:0]             req_c;
    logic [NUM_CPU-1:0][PRIO_W:0]   best_c;

    typedef struct packed {
        logic [NUM_CPU-1:0]             req;
        logic [NUM_CPU-1:0][ID_W-1:0]   hppi;
        logic [NUM_CPU-1:0][PRIO_W:0]   best;
        logic                           upd;
    } out_t;

    out_t o_d, o_q;

    irq_sel_store #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) store_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_cpu(wr_cpu), .wr_id(wr_id), .wr_data(wr_data),
        .en_o(en), .pend_o(pend), .prio_o(prio), .tgt_o(tgt)
    );

    generate
        for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
            for (genvar i = 0; i < NUM_IRQ; i++) begin : g_col
                assign tgt_col[c][i] = tgt[i][c];
            end

            irq_sel_scan #(.NUM_IRQ(NUM_IRQ)) scan_i (
                .en(en[c]), .pend(pend[c]), .prio(prio[c]), .tgt_bit(tgt_col[c]),
                .grp_ok((dist_grp_en != 2'b00) && (cpu_grp_en[2*c +: 2] != 2'b00)),
                .pmask(pmask[8*c +: 8]), .run_prio(run_prio[9*c +: 9]),
                .hppi(hppi_c[c]), .req(req_c[c]), .best_prio(best_c[c])
            );

            assign irq_req_o[c]            = o_q.req[c];
            assign hppi_o[ID_W*c +: ID_W]  = o_q.hppi[c];

            p_grp_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
                ((dist_grp_en == 2'b00) || (cpu_grp_en[2*c +: 2] == 2'b00))
                |=> (hppi_o[ID_W*c +: ID_W] == SPURIOUS_ID && !irq_req_o[c]));
            p_req_has_id_r7: assert property (@(posedge clk) disable iff (!rst_n)
                irq_req_o[c] |-> (hppi_o[ID_W*c +: ID_W] != SPURIOUS_ID));
            p_req_below_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
                irq_req_o[c] |-> (o_q.best[c] < $past(run_prio[9*c +: 9])));
            p_id_below_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (hppi_o[ID_W*c +: ID_W] != SPURIOUS_ID)
                |-> (o_q.best[c] < {1'b0, $past(pmask[8*c +: 8])}));
        end
    endgenerate

    always_comb begin
        o_d      = o_q;
        o_d.req  = req_c;
        o_d.hppi = hppi_c;
        o_d.best = best_c;
        o_d.upd  = wr_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q      <= '0;
            o_q.hppi <= {NUM_CPU{SPURIOUS_ID}};
            o_q.best <= {NUM_CPU{9'h100}};
        end else begin
            o_q <= o_d;
        end
    end

    assign settled_o = !o_q.upd;

    p_settle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !settled_o);
endmodule

// File: tb/irq_hp_select_tb_top.sv
module irq_hp_select_tb_top;
    localparam int NC = 2;
    localparam int NI = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [1:0]      wr_kind = '0;
    logic [0:0]      wr_cpu = '0;
    logic [9:0]      wr_id = '0;
    logic [7:0]      wr_data = '0;
    logic [1:0]      dist_grp_en = 2'b01;
    logic [2*NC-1:0] cpu_grp_en = 4'b0101;
    logic [8*NC-1:0] pmask = 16'hFFFF;
    logic [9*NC-1:0] run_prio = {9'h100, 9'h100};
    logic [NC-1:0]   irq_req_o;
    logic [10*NC-1:0] hppi_o;
    logic            settled_o;

    always #4 clk = ~clk;

    irq_hp_select #(.NUM_CPU(NC), .NUM_IRQ(NI)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_cpu(wr_cpu), .wr_id(wr_id), .wr_data(wr_data),
        .dist_grp_en(dist_grp_en), .cpu_grp_en(cpu_grp_en), .pmask(pmask),
        .run_prio(run_prio), .irq_req_o(irq_req_o), .hppi_o(hppi_o),
        .settled_o(settled_o)
    );

    typedef struct {
        int    cpu;
        int    hppi;
        bit    req;
        string tag;
    } exp_t;

    exp_t expq[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;

    bit        m_en[NC][NI];
    bit        m_pd[NC][NI];
    int        m_pr[NC][NI];
    bit [NC-1:0] m_tg[NI];

    task automatic chk(bit ok, string tag, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic void model(int c, output int h, output bit r);
        int bp = 256;
        int bi = 1023;
        h = 1023;
        r = 0;
        if (dist_grp_en == 0 || cpu_grp_en[2*c +: 2] == 0) return;
        for (int i = 0; i < NI; i++)
            if (m_en[c][i] && m_pd[c][i] && (i < 32 || m_tg[i][c]) && m_pr[c][i] < bp) begin
                bp = m_pr[c][i];
                bi = i;
            end
        if (bp < int'(pmask[8*c +: 8])) begin
            h = bi;
            r = bp < int'(run_prio[9*c +: 9]);
        end
    endfunction

    // driver side: write one entry, R9 settle flag checked after acceptance
    task automatic wr(int kind, int cpu, int id, int data);
        wr_kind = 2'(kind);
        wr_cpu  = 1'(cpu);
        wr_id   = 10'(id);
        wr_data = 8'(data);
        wr_en   = 1'b1;
        @(negedge clk);
        chk(settled_o == 1'b0, "R9 settled low after write", int'(settled_o), 0);
        #1 wr_en = 1'b0;
        if (id < NI)
            for (int c = 0; c < NC; c++) begin
                if (id >= 32 || c == cpu) begin
                    if (kind == 0) m_en[c][id] = data[0];
                    if (kind == 1) m_pd[c][id] = data[0];
                    if (kind == 3) m_pr[c][id] = data & 8'hFF;
                end
            end
        if (kind == 2 && id >= 32 && id < NI) m_tg[id] = NC'(data);
    endtask

    task automatic expect_all(string tag);
        int h;
        bit r;
        repeat (2) @(negedge clk);
        chk(settled_o == 1'b1, "R9 settled high", int'(settled_o), 1);
        #1;
        for (int c = 0; c < NC; c++) begin
            model(c, h, r);
            expq.push_back('{cpu: c, hppi: h, req: r, tag: tag});
        end
        @(negedge clk);
        #1;
    endtask

    // monitor side: pops expected items and compares against the ports
    initial begin
        forever begin
            @(negedge clk);
            while (expq.size() > 0) begin
                exp_t e;
                e = expq.pop_front();
                chk(int'(hppi_o[10*e.cpu +: 10]) == e.hppi, {e.tag, " hppi"},
                    int'(hppi_o[10*e.cpu +: 10]), e.hppi);
                chk(irq_req_o[e.cpu] == e.req, {e.tag, " req"},
                    int'(irq_req_o[e.cpu]), int'(e.req));
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(hppi_o[9:0] == 10'd1023, "R1 cpu0 hppi", int'(hppi_o[9:0]), 1023);
        chk(hppi_o[19:10] == 10'd1023, "R1 cpu1 hppi", int'(hppi_o[19:10]), 1023);
        chk(irq_req_o == 2'b00, "R1 req", int'(irq_req_o), 0);
        chk(settled_o == 1'b1, "R1 settled", int'(settled_o), 1);
        #1;
        expect_all("R1 idle");

        // R5: shared line aimed at cpu0 only
        wr(3, 0, 40, 8'h40); wr(2, 0, 40, 1); wr(0, 0, 40, 1); wr(1, 0, 40, 1);
        expect_all("R5 target cpu0");
        // R2: more urgent shared line for both CPUs
        wr(3, 0, 45, 8'h20); wr(2, 0, 45, 3); wr(0, 0, 45, 1); wr(1, 0, 45, 1);
        expect_all("R2 lower value wins");
        // R3: equal priority, higher ID loses
        wr(3, 0, 50, 8'h20); wr(2, 0, 50, 3); wr(0, 0, 50, 1); wr(1, 0, 50, 1);
        expect_all("R3 tie shared");
        // R4 and R3: private line on cpu1 only, ties with 45 and wins on ID
        wr(3, 1, 5, 8'h20); wr(0, 1, 5, 1); wr(1, 1, 5, 1);
        expect_all("R4 private bank");
        // R5: target write to private ID ignored
        wr(2, 1, 5, 0);
        expect_all("R5 private target ignored");
        // R4: enabled but not pending, most urgent
        wr(3, 0, 60, 0); wr(2, 0, 60, 3); wr(0, 0, 60, 1);
        expect_all("R4 not pending");
        // R4: pending but disabled
        wr(3, 0, 61, 0); wr(2, 0, 61, 3); wr(1, 0, 61, 1);
        expect_all("R4 not enabled");
        // R6: mask equal to winner priority hides it, one above reveals it
        #1 pmask[7:0] = 8'h20;
        expect_all("R6 mask equal");
        pmask[7:0] = 8'h21;
        expect_all("R6 mask above");
        // R7: running priority threshold
        run_prio[8:0] = 9'h020;
        expect_all("R7 run equal");
        run_prio[8:0] = 9'h021;
        expect_all("R7 run above");
        // R8: group gating
        dist_grp_en = 2'b00;
        expect_all("R8 dist off");
        dist_grp_en = 2'b10;
        cpu_grp_en  = 4'b0001;
        expect_all("R8 cpu1 off");
        cpu_grp_en  = 4'b1001;
        // R2: clearing the winner's pending moves selection to 50
        wr(1, 0, 45, 0);
        expect_all("R2 after clear");
        // R4: ID beyond the line count is ignored
        wr(3, 0, 70, 0);
        expect_all("R4 out of range");
        repeat (2) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule